// File: doc/BRIEF.md
# CPU-Mapped SPI Mode-0 Master Port

This block connects an 8-bit processor bus to an SPI link, for peripherals such as SD cards and network controllers. Each transfer is one full-duplex byte in clock mode 0. The serial clock idles low. The incoming line is sampled on each rising edge, and the outgoing line changes on each falling edge. The most significant bit goes first in both directions.

The transmit byte and the received byte are held in two separate registers. Incoming bits never overwrite the transmit value. This lets the processor resend a filler byte such as 0xFF many times while it reads a data block. One address bit, the start-select bit, decides what an access does. With that bit clear, an access only reads the received byte or loads the transmit byte. With it set, the access also launches a transfer. A read with the bit set returns the byte from the earlier transfer and sends the stored transmit byte. A write with the bit set sends the byte just written.

All address bits below the start-select bit are ignored, and so are the bits above it. The port therefore answers on a window of consecutive addresses, so a block-move instruction that increments its address on every byte keeps reaching the same function. An outside decoder supplies the chip-select. The port has no busy flag: the serial clock, a divided copy of the system clock, must be fast enough to finish each byte before the processor accesses the port again.

Top module: `spi_bus_port`

## Requirements
- R1: `sclk` is low whenever no transfer is running. During a transfer `mosi` changes only at a falling edge of `sclk`, or in the cycle a transfer starts.
- R2: A transfer produces exactly 8 rising edges of `sclk`. The byte sent on `mosi` and the byte captured from `miso` both run most significant bit first. The captured byte becomes readable on `rdata`.
- R3: The transmit register keeps its value through any number of transfers. Repeated reads with the start-select bit set send the same byte each time.
- R4: A read (`cs`=1, `we`=0) with `addr[SEL_BIT]`=0 returns the last received byte on `rdata` and produces no `sclk` activity.
- R5: A read with `addr[SEL_BIT]`=1 returns the byte received before this access and starts a transfer that sends the current transmit value.
- R6: A write (`cs`=1, `we`=1) with `addr[SEL_BIT]`=0 loads `wdata` into the transmit register, starts no transfer and leaves `rdata` unchanged.
- R7: A write with `addr[SEL_BIT]`=1 loads `wdata` and starts a transfer that sends that new byte.
- R8: Every address bit other than `SEL_BIT` has no effect on which function an access performs.
- R9: A start request that arrives while a transfer runs does not restart, extend or queue a transfer. A write in that request still loads the transmit register for later use.
- R10: In the cycle after a starting access, `mosi` carries bit 7 and `sclk` is low. `sclk` rises after `HALF_DIV` cycles and keeps a half period of `HALF_DIV` cycles. A transfer lasts 16×`HALF_DIV` cycles. The received byte appears on `rdata` at the eighth rising edge.
- R11: After reset, `sclk`, `mosi` and `rdata` are 0 and the transmit register holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | One-cycle access strobe from the outside address decoder |
| we | input | 1 | 1 for a write access, 0 for a read access |
| addr | input | ADDR_W | Bus address; only bit SEL_BIT is used, as the start-select bit |
| wdata | input | 8 | Byte written to the transmit register |
| rdata | output | 8 | Last received byte |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data toward the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a running byte. The processor is expected never to do this, and the port gives no sign that a byte is still running. The bench counts cycles from its own starting write and sends a second starting write a few cycles in. It then checks three things: the loopback slave received only the first byte, exactly eight clock rises occurred, and a later start sends the byte loaded by the ignored request. The data path is swept through all 256 transmit values against computed slave bytes. Each pass uses a different pattern on the ignored address bits.

// File: rtl/spi_bus_port.sv
module spi_bus_port #(
  parameter int ADDR_W   = 16,
  parameter int SEL_BIT  = 9,
  parameter int HALF_DIV = 4,
  parameter int DW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(DW);

  logic          busy, sclk_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] tx_q, sh, rx_q;
  logic [DW-2:0] rxs;
  logic          unused_addr;

  assign unused_addr = ^addr;

  wire go   = cs & addr[SEL_BIT] & ~busy;
  wire tick = (cnt == CW'(HALF_DIV - 1));
  wire last = (bitn == BW'(DW - 1));

  assign sclk  = sclk_q;
  assign mosi  = sh[DW-1];
  assign rdata = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            tx_q <= '1;
    else if (cs && we)     tx_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rxs    <= '0;
      rx_q   <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxs    <= {rxs[DW-3:0], miso};
          if (last) rx_q <= {rxs, miso};
        end else begin
          sclk_q <= 1'b0;
          sh     <= {sh[DW-2:0], 1'b0};
          bitn   <= bitn + 1'b1;
          if (last) busy <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (go) begin
      busy   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= we ? wdata : tx_q;
    end
  end
endmodule

module spi_bus_port_chk #(
  parameter int HALF_DIV = 4,
  parameter int DW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic          sclk,
  input logic          mosi,
  input logic [DW-1:0] rdata,
  input logic          busy,
  input logic [DW-1:0] tx_q
);
  logic sclk_d, busy_d;
  int   rises, cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      busy_d <= 1'b0;
      rises  <= 0;
      cyc    <= 0;
    end else begin
      sclk_d <= sclk;
      busy_d <= busy;
      if (busy && !busy_d)      rises <= 0;
      else if (sclk && !sclk_d) rises <= rises + 1;
      cyc <= busy ? cyc + 1 : 0;
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R1
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sclk) || $rose(busy)));
  // R2
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rises == DW);
  // R10
  length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc == 2 * DW * HALF_DIV);
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(busy));
  // R6
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_q) |-> $past(cs && we));
endmodule

bind spi_bus_port spi_bus_port_chk #(.HALF_DIV(HALF_DIV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .sclk(sclk), .mosi(mosi),
  .rdata(rdata), .busy(busy), .tx_q(tx_q)
);

// File: tb/spi_bus_port_test.sv
module spi_bus_port_test;
  localparam int DIV = 2;
  localparam int XFER = 16 * DIV;

  logic clk = 0, rst_n = 0, cs = 0, we = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sclk, mosi, miso;

  int checks = 0, errors = 0, sck_n = 0;

  logic [7:0] sl_sh = '0, sl_new = '0;
  logic sl_cap = 0, sl_load = 0;

  always #10 clk = ~clk;

  spi_bus_port #(.HALF_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign miso = sl_sh[7];

  always @(posedge sclk or negedge sclk or posedge sl_load) begin
    if (sl_load)   sl_sh <= sl_new;
    else if (sclk) sl_cap <= mosi;
    else           sl_sh <= {sl_sh[6:0], sl_cap};
  end

  always @(posedge sclk) sck_n++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] v);
    sl_new = v;
    #1 sl_load = 1;
    #1 sl_load = 0;
  endtask

  task automatic access(input bit w, input bit st, input logic [8:0] low,
                        input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    cs = 1; we = w; wdata = d;
    addr = {low[5:0] ^ 6'h2a, st, low};
    #1 rd = rdata;
    @(negedge clk);
    cs = 0; we = 0; addr = '0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] rd, s, last_s;
    int c0;
    waitn(4);
    rst_n = 1;
    waitn(1);
    // R11 reset state
    chk(sclk == 0, "R11 sclk", sclk, 0);
    chk(mosi == 0, "R11 mosi", mosi, 0);
    chk(rdata == 0, "R11 rdata", rdata, 0);

    // R5 read-start after reset sends reset TX 0xFF
    preload(8'h5a);
    c0 = sck_n;
    access(0, 1, 9'h1f3, 8'h00, rd);
    chk(rd == 8'h00, "R5 previous byte", rd, 0);
    waitn(XFER + 4);
    chk(sl_sh == 8'hff, "R11 reset tx", sl_sh, 8'hff);
    chk(sck_n - c0 == 8, "R2 rises", sck_n - c0, 8);
    access(0, 0, 9'h004, 8'h00, rd);
    chk(rd == 8'h5a, "R4 read received", rd, 8'h5a);

    // R10 timing of a write-start
    preload(8'hc3);
    access(1, 1, 9'h0a0, 8'ha6, rd);
    chk(mosi == 1 && sclk == 0, "R10 first bit", {sclk, mosi}, 1);
    waitn(DIV - 1);
    chk(sclk == 0, "R10 sclk low before rise", sclk, 0);
    waitn(1);
    chk(sclk == 1, "R10 sclk rise", sclk, 1);
    waitn(14 * DIV - 1);
    chk(rdata == 8'h5a, "R10 rx before 8th rise", rdata, 8'h5a);
    waitn(1);
    chk(rdata == 8'hc3, "R10 rx at 8th rise", rdata, 8'hc3);
    waitn(DIV);
    chk(sclk == 0, "R1 sclk idle after", sclk, 0);
    waitn(3);
    chk(sl_sh == 8'ha6, "R7 sent byte", sl_sh, 8'ha6);

    // R7 R8 R2 sweep over all transmit values
    last_s = 0;
    for (int i = 0; i < 256; i++) begin
      s = 8'((i * 37 + 11) & 255);
      preload(s);
      c0 = sck_n;
      access(1, 1, 9'((i * 13) & 511), 8'(i), rd);
      waitn(XFER + 4);
      chk(sl_sh == 8'(i), "R7 sweep tx", sl_sh, i);
      chk(sck_n - c0 == 8, "R2 sweep rises", sck_n - c0, 8);
      access(0, 0, 9'((i * 29 + 5) & 511), 8'h00, rd);
      chk(rd == s, "R8 sweep rx", rd, s);
      last_s = s;
    end

    // R3 transmit register persists, repeated read-starts resend it
    for (int k = 0; k < 3; k++) begin
      preload(8'h3c + 8'(k));
      access(0, 1, 9'(k * 100), 8'h00, rd);
      chk(rd == (k == 0 ? last_s : 8'h3c + 8'(k - 1)), "R3 prev rx", rd, 0);
      waitn(XFER + 4);
      chk(sl_sh == 8'hff, "R3 resend", sl_sh, 8'hff);
    end

    // R6 write without start
    c0 = sck_n;
    access(1, 0, 9'h1ff, 8'h81, rd);
    waitn(XFER + 4);
    chk(sck_n == c0, "R6 no clock", sck_n - c0, 0);
    chk(rdata == 8'h3e, "R6 rx unchanged", rdata, 8'h3e);
    preload(8'h11);
    access(0, 1, 9'h000, 8'h00, rd);
    waitn(XFER + 4);
    chk(sl_sh == 8'h81, "R6 loaded tx sent", sl_sh, 8'h81);

    // R4 plain reads are idle
    c0 = sck_n;
    for (int k = 0; k < 4; k++) begin
      access(0, 0, 9'(k * 77), 8'h00, rd);
      chk(rd == 8'h11, "R4 read value", rd, 8'h11);
    end
    waitn(XFER);
    chk(sck_n == c0, "R4 no clock", sck_n - c0, 0);

    // R9 start while busy is ignored
    preload(8'h96);
    c0 = sck_n;
    access(1, 1, 9'h033, 8'h4b, rd);
    waitn(5);
    access(1, 1, 9'h1c0, 8'he1, rd);
    waitn(XFER + 8);
    chk(sck_n - c0 == 8, "R9 rises", sck_n - c0, 8);
    chk(sl_sh == 8'h4b, "R9 first byte kept", sl_sh, 8'h4b);
    chk(rdata == 8'h96, "R9 rx", rdata, 8'h96);
    preload(8'h00);
    access(0, 1, 9'h002, 8'h00, rd);
    waitn(XFER + 4);
    chk(sl_sh == 8'he1, "R9 tx loaded", sl_sh, 8'he1);

    summary();
  end
endmodule